// File: doc/BRIEF.md
# Alternating Dual-Reload PWM Timer

This block is a down-counting timer that produces a pulse-width-modulated waveform with no processor involvement once it is set up. Two reload registers hold the high time and the low time. Each time the counter passes below zero, it reloads from one of the two registers in turn, flips the PWM output and raises an interrupt pending flag. Software changes the waveform only by rewriting a reload register. The new value is used at the next reload that selects that register.

Software reaches the block through single-cycle register writes: the counter, reload register A, reload register B, a control register and a pending-clear register. The control register holds a 3-bit mode field and a high-speed select bit. The count rate is either one step every clock or one step every `SLOW_DIV` clocks. A build parameter can remove the high-speed option.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the counter reads 0, the PWM output is 0, the pending flag is 0, the mode field is 0 (idle) and the high-speed bit is 0.
- R2: While the mode field differs from `PWM_CODE` (default 3'b010), the counter does not count and keeps its value. The PWM output is held at 0 and the next reload is set to come from A. A counter write (address 0) still loads the counter.
- R3: In PWM mode with the high-speed bit (control write data bit 3) at 1, the counter steps down by one every clock. With that bit at 0, it steps once every `SLOW_DIV` clocks (default 10), and the first step lands on the `SLOW_DIV`-th clock edge after the mode is entered.
- R4: A step taken while the counter is 0 is an underflow. In that step the counter loads the selected reload value instead of wrapping, so the value 0 lasts one full count period.
- R5: The first underflow after PWM mode is entered loads from A (address 1), the next from B (address 2), and the loads alternate from then on.
- R6: The PWM output toggles at every underflow and is 0 on entry to PWM mode, so the period loaded from A drives it high.
- R7: Every underflow sets the pending flag. Writing 1 to data bit 0 at address 4 clears it. If a clear and an underflow fall in the same cycle, the flag stays set.
- R8: Writing A or B while the timer runs leaves the current count unchanged. The new value is used at the next reload that selects that register.
- R9: With parameter `HS_EN` = 0, the high-speed bit is ignored and the timer always steps at the slow rate.
- R10: A counter write in PWM mode takes priority over that cycle's step or reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | 0 counter, 1 reload A, 2 reload B, 3 control, 4 pending clear |
| wr_data | input | 16 | Write data. Control uses bits 2:0 for mode and bit 3 for high speed |
| cnt_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM waveform |
| pend_o | output | 1 | Interrupt pending flag |

## Verification
Several input patterns exercise the reload sequence. Short, unequal reload values at high speed make it visible if the A/B order is swapped or the first-load rule is broken. A slow-rate run checks where the prescaler phase starts on mode entry. A mid-run rewrite of A shows whether the new value is applied at once or only at its own next reload. Leaving and re-entering PWM mode shows whether the alternation restarts from A. A pending clear timed to coincide with an underflow checks the set-over-clear priority. A second instance built without the high-speed option, fed the same writes, shows that the high-speed bit has no effect there.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [2:0] {
    ADDR_CNT  = 3'd0,
    ADDR_RLA  = 3'd1,
    ADDR_RLB  = 3'd2,
    ADDR_CTRL = 3'd3,
    ADDR_PEND = 3'd4
  } pwmt_addr_e;
endpackage

// File: rtl/pwmt_tick_gen.sv
module pwmt_tick_gen #(
  parameter int SLOW_DIV = 10,
  parameter bit HS_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hs,
  output logic tick
);
  localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(SLOW_DIV - 1);

  logic [PW-1:0] pc_q, pc_d;
  logic          hs_eff;

  generate
    if (HS_EN) begin : g_hs
      assign hs_eff = hs;
    end else begin : g_no_hs
      assign hs_eff = 1'b0;
    end
  endgenerate

  always_comb begin
    pc_d = pc_q;
    if (!run)              pc_d = '0;
    else if (pc_q == LAST) pc_d = '0;
    else                   pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign tick = run & (hs_eff | (pc_q == LAST));
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wd,
  input  logic [W-1:0] rld_a,
  input  logic [W-1:0] rld_b,
  output logic [W-1:0] cnt,
  output logic         sel_b,
  output logic         pwm,
  output logic         uflow
);
  logic [W-1:0] cnt_d;
  logic         sel_d, pwm_d;

  assign uflow = run & tick & (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    sel_d = sel_b;
    pwm_d = pwm;
    if (!run) begin
      sel_d = 1'b0;
      pwm_d = 1'b0;
    end else if (uflow) begin
      cnt_d = sel_b ? rld_b : rld_a;
      sel_d = ~sel_b;
      pwm_d = ~pwm;
    end else if (tick) begin
      cnt_d = cnt - 1'b1;
    end
    if (cnt_we) cnt_d = cnt_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_b <= 1'b0;
      pwm   <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      sel_b <= sel_d;
      pwm   <= pwm_d;
    end
  end
endmodule

// File: rtl/pwmt_flag.sv
module pwmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_d;

  always_comb pend_d = set | (pend & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int         CNT_W    = 16,
  parameter int         MODE_W   = 3,
  parameter logic [2:0] PWM_CODE = 3'b010,
  parameter int         SLOW_DIV = 10,
  parameter bit         HS_EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             pend_o
);
  import pwmt_pkg::*;

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [CNT_W-1:0]  rld_a, rld_b, rld_a_d, rld_b_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              hs_q, hs_d;
  logic              run, tick, uflow, sel_b, clr_req, cnt_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign cnt_we  = wr_en & (wr_addr == ADDR_CNT);
  assign clr_req = wr_en & (wr_addr == ADDR_PEND) & wr_data[0];
  assign run     = (mode_q == MODE_W'(PWM_CODE));

  always_comb begin
    rld_a_d = rld_a;
    rld_b_d = rld_b;
    mode_d  = mode_q;
    hs_d    = hs_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_RLA:  rld_a_d = wr_data;
        ADDR_RLB:  rld_b_d = wr_data;
        ADDR_CTRL: begin
          mode_d = wr_data[MODE_W-1:0];
          hs_d   = wr_data[MODE_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rld_a  <= '0;
      rld_b  <= '0;
      mode_q <= '0;
      hs_q   <= 1'b0;
    end else begin
      rld_a  <= rld_a_d;
      rld_b  <= rld_b_d;
      mode_q <= mode_d;
      hs_q   <= hs_d;
    end
  end

  pwmt_tick_gen #(.SLOW_DIV(SLOW_DIV), .HS_EN(HS_EN)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .hs(hs_q), .tick(tick)
  );

  pwmt_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tick),
    .cnt_we(cnt_we), .cnt_wd(wr_data), .rld_a(rld_a), .rld_b(rld_b),
    .cnt(cnt_o), .sel_b(sel_b), .pwm(pwm_o), .uflow(uflow)
  );

  pwmt_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set(uflow), .clr(clr_req), .pend(pend_o)
  );
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             cnt_we,
  input logic             clr_req,
  input logic             sel_b,
  input logic [CNT_W-1:0] rld_a,
  input logic [CNT_W-1:0] rld_b,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pwm_o,
  input logic             pend_o
);
  logic at_zero_step;
  assign at_zero_step = run & tick & (cnt_o == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_o));

  // R6
  idle_pwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_o);

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_o != '0 && !cnt_we) |=> (cnt_o == $past(cnt_o) - 1'b1));

  // R5
  reload_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero_step && !cnt_we) |=> (cnt_o == $past(sel_b ? rld_b : rld_a)));

  // R6
  pwm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero_step |=> (pwm_o != $past(pwm_o)));

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero_step |=> pend_o);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !at_zero_step) |=> !pend_o);
endmodule

bind pwm_reload_timer pwmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tick), .cnt_we(cnt_we),
  .clr_req(clr_req), .sel_b(sel_b), .rld_a(rld_a), .rld_b(rld_b),
  .cnt_o(cnt_o), .pwm_o(pwm_o), .pend_o(pend_o)
);

// File: tb/pwm_reload_timer_bench.sv
module pwm_reload_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 10;
  localparam logic [2:0] PWMC = 3'b010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] cnt0, cnt1;
  logic        pwm0, pwm1, pend0, pend1;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  // reference model state, index 0 = high-speed capable, 1 = slow only
  int m_cnt[2], m_a[2], m_b[2], m_mode[2], m_hs[2], m_pc[2];
  int m_sel[2], m_pwm[2], m_pend[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_timer #(.SLOW_DIV(DIV), .HS_EN(1'b1)) u_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt0), .pwm_o(pwm0), .pend_o(pend0));

  pwm_reload_timer #(.SLOW_DIV(DIV), .HS_EN(1'b0)) u_pwm_reload_timer_slow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt1), .pwm_o(pwm1), .pend_o(pend1));

  function automatic bool_run(int k);
    return m_mode[k] == int'(PWMC);
  endfunction

  function automatic bit zero_step_next(int k);
    bit fast;
    fast = (k == 0) && (m_hs[k] != 0);
    return bool_run(k) && (fast || m_pc[k] == DIV-1) && m_cnt[k] == 0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_cnt[k] = 0; m_a[k] = 0; m_b[k] = 0; m_mode[k] = 0; m_hs[k] = 0;
        m_pc[k] = 0; m_sel[k] = 0; m_pwm[k] = 0; m_pend[k] = 0;
      end else begin
        bit run, fast, step, setp;
        run  = bool_run(k);
        fast = (k == 0) && (m_hs[k] != 0);
        step = run && (fast || m_pc[k] == DIV-1);
        setp = 1'b0;
        if (!run) begin
          m_sel[k] = 0; m_pwm[k] = 0;
        end else if (step) begin
          if (m_cnt[k] == 0) begin
            m_cnt[k] = (m_sel[k] != 0) ? m_b[k] : m_a[k];
            m_sel[k] = 1 - m_sel[k];
            m_pwm[k] = 1 - m_pwm[k];
            setp = 1'b1;
          end else m_cnt[k] = m_cnt[k] - 1;
        end
        m_pc[k] = (!run || m_pc[k] == DIV-1) ? 0 : m_pc[k] + 1;
        if (setp) m_pend[k] = 1;
        else if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_pend[k] = 0;
        if (wr_en) begin
          case (wr_addr)
            3'd0: m_cnt[k] = int'(wr_data);
            3'd1: m_a[k] = int'(wr_data);
            3'd2: m_b[k] = int'(wr_data);
            3'd3: begin m_mode[k] = int'(wr_data[2:0]); m_hs[k] = int'(wr_data[3]); end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #(CLK_PERIOD/4);
    if (cmp_on) begin
      chk(cur_req, "cnt", int'(cnt0), m_cnt[0]);
      chk("R6", "pwm", int'(pwm0), m_pwm[0]);
      chk("R7", "pend", int'(pend0), m_pend[0]);
      chk("R9", "slow cnt", int'(cnt1), m_cnt[1]);
      chk("R9", "slow pwm", int'(pwm1), m_pwm[1]);
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1", "cnt", int'(cnt0), 0);
    chk("R1", "pwm", int'(pwm0), 0);
    chk("R1", "pend", int'(pend0), 0);

    // R2 idle mode holds a loaded count
    cur_req = "R2";
    wr(3'd0, 16'd5);
    wr(3'd3, 16'h0009);
    idle(20);
    chk("R2", "held cnt", int'(cnt0), 5);

    // R3/R5 fast run with unequal reloads
    cur_req = "R5";
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd6);
    wr(3'd0, 16'd2);
    wr(3'd3, {12'd0, 1'b1, PWMC});
    idle(40);

    // R7 clear coinciding with an underflow keeps the flag
    cur_req = "R7";
    while (!zero_step_next(0)) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7", "set beats clear", int'(pend0), 1);
    wr(3'd4, 16'd1);
    chk("R7", "cleared", int'(pend0), m_pend[0]);

    // R8 reload rewrite mid-run
    cur_req = "R8";
    wr(3'd1, 16'd8);
    idle(40);

    // R3 slow rate while staying in PWM mode
    cur_req = "R3";
    wr(3'd3, {12'd0, 1'b0, PWMC});
    idle(200);

    // R10 counter write during run
    cur_req = "R10";
    wr(3'd0, 16'd4);
    idle(80);

    // R2/R6 leave and re-enter: restart from A
    cur_req = "R2";
    wr(3'd3, 16'd0);
    idle(15);
    chk("R6", "pwm idle", int'(pwm0), 0);
    cur_req = "R4";
    wr(3'd0, 16'd0);
    wr(3'd3, {12'd0, 1'b1, PWMC});
    idle(60);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule